// File: doc/BRIEF.md
# Planar Intra Prediction Sample Generator

This block produces the planar intra-prediction samples for one square block of side 4, 8, 16 or 32. Reference samples are first written through a simple load port into an internal array of 129 eight-bit entries. A start pulse then launches generation, and the prediction comes out as a stream of 8-sample row segments, one per cycle, followed by a one-cycle completion pulse.

Each predicted sample mixes four reference samples. The left sample of its row and the top-right corner sample are weighted by column position. The top sample of its column and the bottom-left corner sample are weighted by row position. A rounding term equal to the block side is added, and the sum is shifted right so that it is divided by twice the block side.

Control is a three-state machine. IDLE waits for start; on an accepted start (transition *launch*) it captures the size code and moves to EMIT. EMIT produces one beat per cycle. After the final beat (transition *finish*) it moves to WRAP. WRAP raises the completion pulse and returns to IDLE unconditionally (transition *rearm*). A synchronous reset forces IDLE from any state.

Top module: `planar_pred_engine`

## Requirements
- R1: `size_code` 0, 1, 2, 3 selects block side nt = 4, 8, 16, 32. A run then produces exactly 4, 8, 32 or 128 valid beats.
- R2: The sample at (row, col) is ((nt-1-col)·L + (col+1)·TR + (nt-1-row)·T + (row+1)·BL + nt) >> (log2(nt)+1), keeping the low 8 bits. The sum is held in 16 bits.
- R3: Reference index nt-1 holds BL and index 3nt+1 holds TR. Index 2nt-1-row holds L for that row, so the left column is stored bottom-up. Index 2nt+1+col holds T for that column.
- R4: For nt ≥ 8, beats cover 8×8 tiles. Within a tile the rows run top to bottom. The column tiles of one 8-row band come left to right before the next band. `out_row` carries the absolute row and `out_tile` the column tile, and lane k (bits 8k+7:8k) holds column 8·out_tile+k.
- R5: For nt = 4, beat k carries row k with out_tile = 0. Lanes 0..3 hold columns 0..3 and lanes 4..7 are zero.
- R6: A start pulse while a run is in progress is ignored: the run keeps its size and beat count.
- R7: `done` is high for exactly one cycle, in the cycle right after the last valid beat, and never together with `out_valid`.
- R8: Load-port writes made while a run is in progress do not change the reference array.
- R9: Synchronous reset clears `out_valid` and `done` and aborts any run. No beats follow until a new start.
- R10: Beats are contiguous. The first is valid in the second cycle after the clock edge that samples the start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Reference write enable |
| ld_addr | input | 8 | Reference entry index (0..128) |
| ld_data | input | 8 | Reference sample value |
| start | input | 1 | Launch pulse, sampled only in IDLE |
| size_code | input | 2 | Block side select, captured at launch |
| out_valid | output | 1 | Beat valid |
| out_samples | output | 64 | Eight predicted samples, lane k in bits 8k+7:8k |
| out_row | output | 5 | Absolute row of the beat |
| out_tile | output | 2 | Column tile of the beat |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a start or a reference write that arrives in the middle of a 32×32 run. Such a stimulus can only be rejected because the machine is busy. The bench injects a start with a different size code, and separately a write to an array entry used by the run, at chosen beat numbers while EMIT is streaming. It then checks that all 128 beats still match the original size and the unmodified array. A later clean run over the same array shows that the rejected write never landed. A reset in the middle of a run is also forced, to show that the stream stops and that a new launch works afterwards.

// File: rtl/planar_pkg.sv
package planar_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_EMIT = 2'd1,
        S_WRAP = 2'd2
    } plan_state_t;

    // block side for a size code
    function automatic logic [6:0] size_to_nt(input logic [1:0] code);
        return 7'd4 << code;
    endfunction

    // log2(side) + 1
    function automatic logic [2:0] size_to_shift(input logic [1:0] code);
        return 3'(code) + 3'd3;
    endfunction

endpackage

// File: rtl/planar_ref_store.sv
module planar_ref_store #(
    parameter int PIX_W = 8,
    parameter int DEPTH = 129,
    parameter int AW    = 8
) (
    input  logic                        clk,
    input  logic                        wr_en,
    input  logic [AW-1:0]               wr_addr,
    input  logic [PIX_W-1:0]            wr_data,
    input  logic                        lock,
    output logic [DEPTH-1:0][PIX_W-1:0] ref_q
);

    always_ff @(posedge clk) begin
        if (wr_en && !lock && (int'(wr_addr) < DEPTH)) begin
            ref_q[wr_addr] <= wr_data;
        end
    end

endmodule

// File: rtl/planar_lane.sv
module planar_lane #(
    parameter int PIX_W = 8,
    parameter int ACC_W = 16
) (
    input  logic [6:0]       nt,
    input  logic [2:0]       shift,
    input  logic [4:0]       row,
    input  logic [4:0]       col,
    input  logic [PIX_W-1:0] left_px,
    input  logic [PIX_W-1:0] top_px,
    input  logic [PIX_W-1:0] tr_px,
    input  logic [PIX_W-1:0] bl_px,
    output logic [PIX_W-1:0] pred
);

    logic [6:0]       w_left, w_tr, w_top, w_bl;
    logic [ACC_W-1:0] acc;

    always_comb begin
        w_left = nt - 7'd1 - 7'(col);
        w_tr   = 7'(col) + 7'd1;
        w_top  = nt - 7'd1 - 7'(row);
        w_bl   = 7'(row) + 7'd1;
        acc    = ACC_W'(w_left) * ACC_W'(left_px)
               + ACC_W'(w_tr)   * ACC_W'(tr_px)
               + ACC_W'(w_top)  * ACC_W'(top_px)
               + ACC_W'(w_bl)   * ACC_W'(bl_px)
               + ACC_W'(nt);
        pred   = PIX_W'(acc >> shift);
    end

endmodule

// File: rtl/planar_seq.sv
module planar_seq
    import planar_pkg::*;
#(
    parameter int BW = 2,
    parameter int LW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [1:0]    size_in,
    output logic          busy,
    output logic          emit,
    output logic [1:0]    size_q,
    output logic [BW-1:0] band,
    output logic [BW-1:0] tile,
    output logic [LW-1:0] line,
    output logic          done_o
);

    plan_state_t state, state_nx;
    logic [LW-1:0] line_last;
    logic [BW-1:0] tile_last;
    logic          last_beat;

    always_comb begin
        line_last = (size_q == 2'd0) ? LW'((1 << LW) / 2 - 1) : LW'((1 << LW) - 1);
        unique case (size_q)
            2'd0, 2'd1: tile_last = BW'(0);
            2'd2:       tile_last = BW'(1);
            default:    tile_last = BW'(3);
        endcase
        last_beat = (line == line_last) && (tile == tile_last) && (band == tile_last);
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (start) state_nx = S_EMIT;
            S_EMIT:  if (last_beat) state_nx = S_WRAP;
            S_WRAP:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= state_nx;
    end

    assign busy = (state != S_IDLE);
    assign emit = (state == S_EMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            size_q <= 2'd0;
            band   <= '0;
            tile   <= '0;
            line   <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= (state == S_WRAP);
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        size_q <= size_in;
                        band   <= '0;
                        tile   <= '0;
                        line   <= '0;
                    end
                end
                S_EMIT: begin
                    if (line != line_last) begin
                        line <= line + LW'(1);
                    end else begin
                        line <= '0;
                        if (tile != tile_last) begin
                            tile <= tile + BW'(1);
                        end else begin
                            tile <= '0;
                            if (band != tile_last) band <= band + BW'(1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/planar_pred_engine.sv
module planar_pred_engine
    import planar_pkg::*;
#(
    parameter int PIX_W  = 8,
    parameter int MAX_NT = 32,
    parameter int LANES  = 8,
    localparam int REF_N = 4 * MAX_NT + 1,
    localparam int AW    = $clog2(REF_N),
    localparam int BW    = $clog2(MAX_NT / LANES),
    localparam int LW    = $clog2(LANES),
    localparam int RW    = BW + LW
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ld_en,
    input  logic [AW-1:0]          ld_addr,
    input  logic [PIX_W-1:0]       ld_data,
    input  logic                   start,
    input  logic [1:0]             size_code,
    output logic                   out_valid,
    output logic [LANES*PIX_W-1:0] out_samples,
    output logic [RW-1:0]          out_row,
    output logic [BW-1:0]          out_tile,
    output logic                   done
);

    logic                        busy, emit;
    logic [1:0]                  size_q;
    logic [BW-1:0]               band, tile;
    logic [LW-1:0]               line;
    logic [REF_N-1:0][PIX_W-1:0] ref_q;
    logic [6:0]                  nt_v;
    logic [2:0]                  shift_v;
    logic [RW-1:0]               row;
    logic [AW-1:0]               left_idx, tr_idx, bl_idx;
    logic [LANES-1:0][PIX_W-1:0] lane_pred, samp_d;

    planar_seq #(.BW(BW), .LW(LW)) seq_i (
        .clk(clk), .rst(rst), .start(start), .size_in(size_code),
        .busy(busy), .emit(emit), .size_q(size_q),
        .band(band), .tile(tile), .line(line), .done_o(done)
    );

    planar_ref_store #(.PIX_W(PIX_W), .DEPTH(REF_N), .AW(AW)) store_i (
        .clk(clk), .wr_en(ld_en), .wr_addr(ld_addr), .wr_data(ld_data),
        .lock(busy), .ref_q(ref_q)
    );

    always_comb begin
        nt_v     = size_to_nt(size_q);
        shift_v  = size_to_shift(size_q);
        row      = {band, line};
        left_idx = AW'(2 * int'(nt_v) - 1 - int'(row));
        tr_idx   = AW'(3 * int'(nt_v) + 1);
        bl_idx   = AW'(int'(nt_v) - 1);
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [RW-1:0] col;
        logic [AW-1:0] top_idx;
        assign col     = {tile, LW'(g)};
        assign top_idx = AW'(2 * int'(nt_v) + 1 + int'(col));

        planar_lane #(.PIX_W(PIX_W), .ACC_W(16)) lane_i (
            .nt(nt_v), .shift(shift_v), .row(row), .col(col),
            .left_px(ref_q[left_idx]), .top_px(ref_q[top_idx]),
            .tr_px(ref_q[tr_idx]), .bl_px(ref_q[bl_idx]),
            .pred(lane_pred[g])
        );

        if (g >= LANES / 2) begin : g_hi
            assign samp_d[g] = (size_q == 2'd0) ? '0 : lane_pred[g];
        end else begin : g_lo
            assign samp_d[g] = lane_pred[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_samples <= '0;
            out_row     <= '0;
            out_tile    <= '0;
        end else begin
            out_valid <= emit;
            if (emit) begin
                out_samples <= samp_d;
                out_row     <= row;
                out_tile    <= tile;
            end
        end
    end

endmodule

// File: rtl/planar_pred_chk.sv
module planar_pred_chk #(
    parameter int W = 64,
    parameter int BW = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          out_valid,
    input logic          done,
    input logic          busy,
    input logic [1:0]    size_q,
    input logic [BW-1:0] out_tile,
    input logic [W-1:0]  out_samples
);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_beat_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(out_valid) && !out_valid);

    assert_upper_lanes_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && size_q == 2'd0) |-> out_samples[W-1:W/2] == '0);

    assert_single_tile_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && size_q <= 2'd1) |-> out_tile == '0);

    assert_beats_follow_start_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> out_valid);

endmodule

bind planar_pred_engine planar_pred_chk #(.W(LANES*PIX_W), .BW(BW)) chk_i (
    .clk(clk), .rst(rst), .out_valid(out_valid), .done(done), .busy(busy),
    .size_q(size_q), .out_tile(out_tile), .out_samples(out_samples)
);

// File: tb/planar_pred_engine_tb.sv
module planar_pred_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_en = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [7:0]  ld_data = '0;
    logic        start = 1'b0;
    logic [1:0]  size_code = '0;
    logic        out_valid;
    logic [63:0] out_samples;
    logic [4:0]  out_row;
    logic [1:0]  out_tile;
    logic        done;

    int applied = 0;
    int bad = 0;
    int m_ref [129];

    always #5 clk = ~clk;

    planar_pred_engine dut_i (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .start(start), .size_code(size_code), .out_valid(out_valid),
        .out_samples(out_samples), .out_row(out_row), .out_tile(out_tile), .done(done)
    );

    // stimulus table: size code and pattern kind
    localparam int NV = 7;
    localparam int VSIZE [NV] = '{0, 1, 2, 3, 3, 0, 2};
    localparam int VKIND [NV] = '{0, 1, 2, 1, 3, 2, 0};

    task automatic finish_up();
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    endtask

    initial begin
        #2000000;
        applied++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_up();
    end

    function automatic int pat(int kind, int i);
        case (kind)
            0: return (i * 3) & 255;
            1: return ((i * 73 + 41) ^ (i >> 2)) & 255;
            2: return 255;
            default: return (255 - i * 5) & 255;
        endcase
    endfunction

    function automatic int exp_pix(int nt, int row, int col);
        int s, sh, v;
        s = (nt - 1 - col) * m_ref[2*nt - 1 - row] + (col + 1) * m_ref[3*nt + 1]
          + (nt - 1 - row) * m_ref[2*nt + 1 + col] + (row + 1) * m_ref[nt - 1] + nt;
        sh = 1;
        v = nt;
        while (v > 1) begin v = v / 2; sh++; end
        return (s >> sh) & 255;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        applied++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic load_all(input int kind);
        for (int i = 0; i < 129; i++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_addr = 8'(i); ld_data = 8'(pat(kind, i));
            m_ref[i] = pat(kind, i);
        end
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // inj_start / inj_load: beat number at which to inject, -1 for none
    task automatic run_block(input int sz, input int inj_start, input int inj_load,
                             input int inj_addr);
        int nt, nb, k, cyc, tiles, band, tl, ln, er, et;
        bit got_done, prev_v;
        logic [63:0] ev;
        nt = 4 << sz;
        nb = (sz == 0) ? 4 : nt * nt / 8;
        tiles = (sz == 0) ? 1 : nt / 8;
        @(negedge clk);
        start = 1'b1; size_code = 2'(sz);
        @(negedge clk);
        start = 1'b0;
        k = 0; cyc = 0; got_done = 0; prev_v = 0;
        // R10: nothing valid yet, first beat on the next cycle
        check(!out_valid, "R10", "valid too early", out_valid, 0);
        while (!got_done && cyc < 400) begin
            if (out_valid) begin
                if (sz == 0) begin er = k; et = 0; end
                else begin
                    band = k / (8 * tiles); tl = (k / 8) % tiles; ln = k % 8;
                    er = band * 8 + ln; et = tl;
                end
                for (int l = 0; l < 8; l++) begin
                    ev[8*l +: 8] = (sz == 0 && l >= 4) ? 8'd0 : 8'(exp_pix(nt, er, et * 8 + l));
                end
                // R2 R3 R4 R5: samples, row and tile fields
                check(out_samples == ev, "R2/R3/R5", "samples", out_samples, ev);
                check(int'(out_row) == er && int'(out_tile) == et, "R4", "row/tile",
                      {out_row, out_tile}, {5'(er), 2'(et)});
                k++;
            end else if (k > 0 && k < nb) begin
                check(1'b0, "R10", "gap in beats", k, nb);
            end
            if (done) begin
                got_done = 1;
                check(prev_v && !out_valid, "R7", "done timing", prev_v, 1);
            end
            prev_v = out_valid;
            start = (k == inj_start);
            size_code = (k == inj_start) ? 2'd0 : 2'(sz);
            ld_en = (k == inj_load);
            ld_addr = 8'(inj_addr);
            ld_data = 8'(m_ref[inj_addr] ^ 8'h5a);
            @(negedge clk);
            cyc++;
        end
        start = 1'b0; ld_en = 1'b0;
        check(got_done, "R7", "done missing", got_done, 1);
        check(k == nb, "R1/R6", "beat count", k, nb);
        check(!done && !out_valid, "R7", "done width", done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check(!out_valid && !done, "R9", "reset state", {out_valid, done}, 0);
        rst = 1'b0;

        for (int v = 0; v < NV; v++) begin
            load_all(VKIND[v]);
            run_block(VSIZE[v], -1, -1, 0);
        end

        // R6: start with another size while running size 32
        load_all(1);
        run_block(3, 5, -1, 0);
        // R8: write to a used entry (top-right, 3nt+1 = 97) while running
        run_block(3, -1, 7, 97);
        run_block(3, -1, -1, 0);
        // R8: write a left sample of row 3 (2nt-1-3 = 28) mid-run, then recheck
        run_block(2, -1, 4, 28);
        run_block(2, -1, -1, 0);

        // R9: reset in the middle of a run
        @(negedge clk);
        start = 1'b1; size_code = 2'd3;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(!out_valid && !done, "R9", "reset mid-run", {out_valid, done}, 0);
        repeat (4) @(negedge clk);
        check(!out_valid && !done, "R9", "stream stopped", {out_valid, done}, 0);
        run_block(1, -1, -1, 0);
        run_block(0, -1, -1, 0);

        finish_up();
    end

endmodule